// File: doc/BRIEF.md
# Passive SPI Word Monitor

This block listens to a four-wire SPI bus and drives none of its lines. It rebuilds complete data words from the controller-to-peripheral and peripheral-to-controller data lines. The serial clock, both data lines and the chip-select line arrive asynchronously. Each one passes through a synchronizer clocked by a system clock that runs at least four times faster than the serial clock. Edges are found by comparing each synchronized sample with the one taken a cycle earlier.

At run time, software-free configuration inputs select the following:
- clock idle level and clock phase,
- the chip-select active level,
- whether chip select gates capture at all,
- bit order and word length,
- which data lines are captured.

These settings are taken into the block only while chip select is inactive, or at any time when chip select is not used.

Each finished word produces a one-cycle strobe. Both captured values are presented together and hold until the next word. A warning flag marks a word whose first bit was taken while the chip-select line was not at its active level. This can only happen when chip-select gating is switched off.

Top module: `spi_word_monitor`

## Requirements
- R1: Sampling edge: with idle level `cfg_cpol_i` and phase `cfg_cpha_i`, the pairs (0,0) and (1,1) sample both data lines on the rising serial-clock edge. The pairs (0,1) and (1,0) sample on the falling edge.
- R2: Bit placement: with `cfg_lsb_first_i`=0, the k-th sampled bit of a word (k counted from 0) lands at word bit `len-1-k`. With `cfg_lsb_first_i`=1 it lands at bit k. Bits at and above `len` read as zero.
- R3: Word length: `cfg_word_len_i` sets the length from 1 to 32. A value of 0 acts as 1 and values above 32 act as 32. After `len` sampling edges the word is reported, and the next edge starts a new word, so several words may follow within one chip-select period.
- R4: `word_valid_o` is high for exactly one system clock per word. `mosi_word_o`, `miso_word_o` and `word_cs_warn_o` change only in that cycle and hold otherwise.
- R5: With `cfg_cs_used_i`=1, chip select is active when `cs_i` equals `cfg_cs_high_i` (0 means active-low). No bit is captured while chip select is inactive.
- R6: With `cfg_cs_used_i`=1, every change of the chip-select line, in either direction, drops any partial word. The next captured bit starts a fresh word.
- R7: `cfg_mosi_en_i` and `cfg_miso_en_i` enable capture of each data line separately. A disabled line reports a zero word.
- R8: With `cfg_cs_used_i`=0, capture runs regardless of `cs_i`, and chip-select changes do not drop partial words. `word_cs_warn_o` is set for a word whose first bit was sampled while `cs_i` was not at its active level. With `cfg_cs_used_i`=1 the flag is always 0.
- R9: After reset `word_valid_o`, both words and `word_cs_warn_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the bus (asynchronous) |
| mosi_i | input | 1 | Controller-to-peripheral data line |
| miso_i | input | 1 | Peripheral-to-controller data line |
| cs_i | input | 1 | Chip-select line |
| cfg_cpol_i | input | 1 | Serial-clock idle level |
| cfg_cpha_i | input | 1 | 0: sample on leading edge, 1: on trailing edge |
| cfg_cs_high_i | input | 1 | 1: chip select active high, 0: active low |
| cfg_cs_used_i | input | 1 | 1: chip select gates capture and clears partial words |
| cfg_lsb_first_i | input | 1 | 1: first bit is the word's bit 0 |
| cfg_word_len_i | input | 6 | Bits per word, 1 to 32 |
| cfg_mosi_en_i | input | 1 | Capture the controller-to-peripheral line |
| cfg_miso_en_i | input | 1 | Capture the peripheral-to-controller line |
| word_valid_o | output | 1 | One-cycle strobe per completed word |
| mosi_word_o | output | 32 | Last completed controller-to-peripheral word |
| miso_word_o | output | 32 | Last completed peripheral-to-controller word |
| word_cs_warn_o | output | 1 | Word began while chip select was inactive |

## Verification
The following properties are checked on every cycle:
- the strobe lasts one cycle;
- the outputs stay frozen between strobes;
- a chip-select change leaves the bit counter at zero in the following cycle;
- every strobe follows a selected sampling edge.

Only the bench scenarios can show the rest. That covers the correct edge choice in each of the four modes, bit placement for both orders and for lengths 1, 5, 8, 12 and 32, and back-to-back words. It also covers partial-word discard, inactive-select suppression under both polarities, per-line disable, and the warning flag when gating is off.

// File: rtl/spi_mon_pkg.sv
package spi_mon_pkg;
  localparam int unsigned MON_W     = 32;
  localparam int unsigned MON_CNT_W = $clog2(MON_W + 1);

  typedef struct packed {
    logic                 cpol;
    logic                 cpha;
    logic                 lsb_first;
    logic                 mosi_en;
    logic                 miso_en;
    logic [MON_CNT_W-1:0] len;
  } mon_cfg_t;

  function automatic logic [MON_CNT_W-1:0] clamp_len(input logic [MON_CNT_W-1:0] l);
    if (l == '0) return MON_CNT_W'(1);
    if (l > MON_CNT_W'(MON_W)) return MON_CNT_W'(MON_W);
    return l;
  endfunction
endpackage

// File: rtl/spi_mon_sync.sv
module spi_mon_sync #(
  parameter int unsigned N      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe[s] <= '0;
        else         pipe[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe[s] <= '0;
        else         pipe[s] <= pipe[s-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/spi_mon_edge.sv
module spi_mon_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_s_i,
  input  logic cs_s_i,
  input  logic cpol_i,
  input  logic cpha_i,
  input  logic cs_high_i,
  input  logic cs_used_i,
  output logic sample_o,
  output logic cs_active_o,
  output logic cs_flip_o
);
  logic sclk_q, cs_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b0;
    end else begin
      sclk_q <= sclk_s_i;
      cs_q   <= cs_s_i;
    end

  logic rise, fall;
  assign rise = sclk_s_i & ~sclk_q;
  assign fall = ~sclk_s_i & sclk_q;

  // modes 1 and 2 sample on falling edge
  assign sample_o    = (cpol_i ^ cpha_i) ? fall : rise;
  assign cs_active_o = cs_high_i ? cs_s_i : ~cs_s_i;
  assign cs_flip_o   = cs_used_i & (cs_s_i ^ cs_q);
endmodule

// File: rtl/spi_mon_shift.sv
module spi_mon_shift
  import spi_mon_pkg::*;
#(
  parameter int unsigned W     = MON_W,
  parameter int unsigned CNT_W = MON_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mon_cfg_t         cfg_i,
  input  logic             clear_i,
  input  logic             cap_i,
  input  logic             mosi_i,
  input  logic             miso_i,
  input  logic             warn_i,
  output logic             valid_o,
  output logic [W-1:0]     mosi_word_o,
  output logic [W-1:0]     miso_word_o,
  output logic             warn_o,
  output logic [CNT_W-1:0] bit_cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     acc_mosi_q, acc_miso_q;
  logic             warn_q;

  logic [CNT_W-1:0] pos;
  logic             first, last, warn_nxt;
  logic [W-1:0]     nxt_mosi, nxt_miso;

  always_comb begin
    first    = (cnt_q == '0);
    last     = (cnt_q + CNT_W'(1)) >= cfg_i.len;
    pos      = cfg_i.lsb_first ? cnt_q : (cfg_i.len - CNT_W'(1) - cnt_q);
    nxt_mosi = (first ? '0 : acc_mosi_q) | ({{(W-1){1'b0}}, mosi_i & cfg_i.mosi_en} << pos);
    nxt_miso = (first ? '0 : acc_miso_q) | ({{(W-1){1'b0}}, miso_i & cfg_i.miso_en} << pos);
    warn_nxt = first ? warn_i : warn_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q       <= '0;
      acc_mosi_q  <= '0;
      acc_miso_q  <= '0;
      warn_q      <= 1'b0;
      valid_o     <= 1'b0;
      mosi_word_o <= '0;
      miso_word_o <= '0;
      warn_o      <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (clear_i) begin
        cnt_q <= '0;
      end else if (cap_i) begin
        acc_mosi_q <= nxt_mosi;
        acc_miso_q <= nxt_miso;
        warn_q     <= warn_nxt;
        if (last) begin
          cnt_q       <= '0;
          valid_o     <= 1'b1;
          mosi_word_o <= nxt_mosi;
          miso_word_o <= nxt_miso;
          warn_o      <= warn_nxt;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end

  assign bit_cnt_o = cnt_q;

  // R4
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R4
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(mosi_word_o) && $stable(miso_word_o) && $stable(warn_o)));
endmodule

// File: rtl/spi_word_monitor.sv
module spi_word_monitor
  import spi_mon_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sclk_i,
  input  logic                 mosi_i,
  input  logic                 miso_i,
  input  logic                 cs_i,
  input  logic                 cfg_cpol_i,
  input  logic                 cfg_cpha_i,
  input  logic                 cfg_cs_high_i,
  input  logic                 cfg_cs_used_i,
  input  logic                 cfg_lsb_first_i,
  input  logic [MON_CNT_W-1:0] cfg_word_len_i,
  input  logic                 cfg_mosi_en_i,
  input  logic                 cfg_miso_en_i,
  output logic                 word_valid_o,
  output logic [MON_W-1:0]     mosi_word_o,
  output logic [MON_W-1:0]     miso_word_o,
  output logic                 word_cs_warn_o
);
  localparam int unsigned NSYNC = 4;

  logic [NSYNC-1:0] raw, syn;
  logic sclk_s, mosi_s, miso_s, cs_s;

  assign raw = {cs_i, miso_i, mosi_i, sclk_i};

  spi_mon_sync #(.N(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn)
  );

  assign {cs_s, miso_s, mosi_s, sclk_s} = syn;

  mon_cfg_t cfg_q;
  logic     sample, cs_active, cs_flip, capture;

  spi_mon_edge u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_s_i   (sclk_s),
    .cs_s_i     (cs_s),
    .cpol_i     (cfg_q.cpol),
    .cpha_i     (cfg_q.cpha),
    .cs_high_i  (cfg_cs_high_i),
    .cs_used_i  (cfg_cs_used_i),
    .sample_o   (sample),
    .cs_active_o(cs_active),
    .cs_flip_o  (cs_flip)
  );

  // configuration is taken only while the bus is idle
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cfg_q <= '{cpol: 1'b0, cpha: 1'b0, lsb_first: 1'b0, mosi_en: 1'b1,
                 miso_en: 1'b1, len: MON_CNT_W'(8)};
    end else if (!cfg_cs_used_i || !cs_active) begin
      cfg_q.cpol      <= cfg_cpol_i;
      cfg_q.cpha      <= cfg_cpha_i;
      cfg_q.lsb_first <= cfg_lsb_first_i;
      cfg_q.mosi_en   <= cfg_mosi_en_i;
      cfg_q.miso_en   <= cfg_miso_en_i;
      cfg_q.len       <= clamp_len(cfg_word_len_i);
    end

  assign capture = sample & (~cfg_cs_used_i | cs_active) & ~cs_flip;

  logic [MON_CNT_W-1:0] bit_cnt;

  spi_mon_shift u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_i      (cfg_q),
    .clear_i    (cs_flip),
    .cap_i      (capture),
    .mosi_i     (mosi_s),
    .miso_i     (miso_s),
    .warn_i     (~cfg_cs_used_i & ~cs_active),
    .valid_o    (word_valid_o),
    .mosi_word_o(mosi_word_o),
    .miso_word_o(miso_word_o),
    .warn_o     (word_cs_warn_o),
    .bit_cnt_o  (bit_cnt)
  );

  // R6
  cs_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_flip |=> (bit_cnt == '0));

  // R1
  valid_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> $past(sample));
endmodule

// File: tb/spi_word_monitor_bench.sv
`timescale 1ns/1ps
module spi_word_monitor_bench;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic sclk = 0, mosi = 0, miso = 0, cs = 1;
  logic cpol = 0, cpha = 0, cs_hi = 0, cs_used = 1, lsb = 0, mo_en = 1, mi_en = 1;
  logic [5:0] wlen = 6'd8;
  logic        vld, warn;
  logic [31:0] mo_w, mi_w;

  spi_word_monitor u_spi_word_monitor (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .mosi_i(mosi), .miso_i(miso), .cs_i(cs),
    .cfg_cpol_i(cpol), .cfg_cpha_i(cpha), .cfg_cs_high_i(cs_hi), .cfg_cs_used_i(cs_used),
    .cfg_lsb_first_i(lsb), .cfg_word_len_i(wlen), .cfg_mosi_en_i(mo_en), .cfg_miso_en_i(mi_en),
    .word_valid_o(vld), .mosi_word_o(mo_w), .miso_word_o(mi_w), .word_cs_warn_o(warn)
  );

  int total = 0, bad = 0, nwords = 0;
  logic vld_prev = 0, multi = 0;

  always @(negedge clk) begin
    if (vld) nwords++;
    if (vld && vld_prev) multi = 1;
    vld_prev = vld;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] msk(input int len, input logic [31:0] v);
    return (len >= 32) ? v : (v & ((32'd1 << len) - 32'd1));
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_set(input bit active);
    cs = active ? cs_hi : ~cs_hi;
    idle(H);
  endtask

  task automatic mode(input logic pl, input logic ph, input logic lb, input int len);
    cpol = pl; cpha = ph; lsb = lb; wlen = 6'(len); sclk = pl;
    idle(6);
  endtask

  task automatic send_bits(input int from, input int n, input int len, input logic [31:0] mv,
                           input logic [31:0] sv);
    for (int k = from; k < from + n; k++) begin
      int idx = lsb ? k : len - 1 - k;
      if (!cpha) begin
        mosi = mv[idx]; miso = sv[idx]; idle(H);
        sclk = ~cpol; idle(H);
        sclk = cpol;
      end else begin
        sclk = ~cpol; mosi = mv[idx]; miso = sv[idx]; idle(H);
        sclk = cpol; idle(H);
      end
    end
    idle(H);
  endtask

  typedef struct packed {
    logic pl; logic ph; logic lb; logic [5:0] len; logic [31:0] mv; logic [31:0] sv;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{1'b0, 1'b0, 1'b0, 6'd8,  32'h000000A5, 32'h0000003C},
    '{1'b0, 1'b1, 1'b0, 6'd8,  32'h0000005A, 32'h000000C3},
    '{1'b1, 1'b0, 1'b0, 6'd8,  32'h00000081, 32'h0000007E},
    '{1'b1, 1'b1, 1'b0, 6'd8,  32'h00000013, 32'h000000EC},
    '{1'b0, 1'b0, 1'b1, 6'd8,  32'h000000B4, 32'h0000002D},
    '{1'b1, 1'b1, 1'b1, 6'd12, 32'h00000ABC, 32'h00000123},
    '{1'b0, 1'b1, 1'b0, 6'd32, 32'hDEADBEEF, 32'h12345678},
    '{1'b1, 1'b0, 1'b1, 6'd1,  32'h00000001, 32'h00000000},
    '{1'b0, 1'b0, 1'b0, 6'd5,  32'h00000015, 32'h0000000A}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int n0;
    logic [31:0] hm, hs;
    idle(3);
    // R9 reset state
    chk(!vld && mo_w == 0 && mi_w == 0 && !warn, "R9", {vld, warn, mo_w[29:0]}, 0);
    rst_n = 1'b1;
    idle(8);

    // table: mode, order and length sweep (R1, R2, R3)
    foreach (VECS[i]) begin
      mode(VECS[i].pl, VECS[i].ph, VECS[i].lb, int'(VECS[i].len));
      n0 = nwords;
      cs_set(1);
      send_bits(0, int'(VECS[i].len), int'(VECS[i].len), VECS[i].mv, VECS[i].sv);
      chk(nwords == n0 + 1, "R1 word count", nwords - n0, 1);
      chk(mo_w == msk(VECS[i].len, VECS[i].mv), "R2 mosi word", mo_w, msk(VECS[i].len, VECS[i].mv));
      chk(mi_w == msk(VECS[i].len, VECS[i].sv), "R3 miso word", mi_w, msk(VECS[i].len, VECS[i].sv));
      chk(!warn, "R8 warn with cs used", warn, 0);
      cs_set(0);
    end

    // R3 back-to-back words within one select period
    mode(0, 0, 0, 8);
    n0 = nwords;
    cs_set(1);
    send_bits(0, 8, 8, 32'h11, 32'h22);
    send_bits(0, 8, 8, 32'h9C, 32'h6D);
    chk(nwords == n0 + 2, "R3 two words", nwords - n0, 2);
    chk(mo_w == 32'h9C && mi_w == 32'h6D, "R3 second word", mo_w, 32'h9C);
    // R4 hold and pulse width
    hm = mo_w; hs = mi_w;
    idle(30);
    chk(mo_w == hm && mi_w == hs, "R4 hold", mo_w, hm);
    cs_set(0);

    // R5 inactive select ignored (active-low)
    n0 = nwords;
    send_bits(0, 8, 8, 32'hFF, 32'hFF);
    chk(nwords == n0 && mo_w == hm, "R5 ignored while inactive", nwords - n0, 0);

    // R5 active-high polarity
    cs_hi = 1; cs = 0; idle(6);
    n0 = nwords;
    cs_set(1);
    send_bits(0, 8, 8, 32'h3A, 32'hC5);
    chk(nwords == n0 + 1 && mo_w == 32'h3A && mi_w == 32'hC5, "R5 active high", mo_w, 32'h3A);
    cs_set(0);
    n0 = nwords;
    send_bits(0, 8, 8, 32'h00, 32'h00);
    chk(nwords == n0 && mo_w == 32'h3A, "R5 high-polarity inactive", mo_w, 32'h3A);
    cs_hi = 0; cs = 1; idle(6);

    // R6 partial word dropped on select change
    n0 = nwords;
    cs_set(1);
    send_bits(0, 5, 8, 32'hFF, 32'hFF);
    cs_set(0);
    cs_set(1);
    chk(nwords == n0, "R6 no word from partial", nwords - n0, 0);
    send_bits(0, 8, 8, 32'h00, 32'h00);
    chk(nwords == n0 + 1 && mo_w == 32'h00 && mi_w == 32'h00, "R6 fresh word", mo_w, 0);
    cs_set(0);

    // R7 per-line disable
    mi_en = 0; idle(4);
    cs_set(1);
    send_bits(0, 8, 8, 32'h77, 32'hEE);
    chk(mo_w == 32'h77 && mi_w == 32'h00, "R7 miso off", mi_w, 0);
    cs_set(0);
    mi_en = 1; mo_en = 0; idle(4);
    cs_set(1);
    send_bits(0, 8, 8, 32'h77, 32'hEE);
    chk(mo_w == 32'h00 && mi_w == 32'hEE, "R7 mosi off", mo_w, 0);
    cs_set(0);
    mo_en = 1; idle(4);

    // R8 select unused: capture with line inactive, warn set
    cs_used = 0; idle(6);
    n0 = nwords;
    send_bits(0, 8, 8, 32'h5C, 32'hA3);
    chk(nwords == n0 + 1 && mo_w == 32'h5C, "R8 capture without select", mo_w, 32'h5C);
    chk(warn, "R8 warn set", warn, 1);
    // R8 select change does not drop partial word when unused
    cs = 0; idle(H);
    send_bits(0, 3, 8, 32'hC6, 32'h39);
    cs = 1; idle(H);
    send_bits(3, 5, 8, 32'hC6, 32'h39);
    chk(nwords == n0 + 2 && mo_w == 32'hC6 && mi_w == 32'h39, "R8 no clear when unused", mo_w, 32'hC6);
    chk(!warn, "R8 warn clear (line active at first bit)", warn, 0);
    cs_used = 1; idle(6);

    chk(!multi, "R4 single-cycle strobe", multi, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule